// File: doc/BRIEF.md
# Interrupt Mask and Serial-Bit Register

This block keeps the interrupt-control state of a small 8-bit processor core. The core writes it one byte at a time through a set-mask command and reads it back as a packed status byte. A single written byte can change three things, each only when its own enable bit in that byte is set:

- the three maskable-interrupt mask bits;
- a one-bit serial output latch;
- the pending flag of the highest-priority maskable input, which the byte can clear.

The block also holds the global interrupt-enable flip-flop. Enable and disable strobes set and clear it. Acceptance of any interrupt also clears it.

There are three request inputs. The highest-priority one (`irq_hi`) is rising-edge sensitive and latched in a pending flip-flop. The two lower ones (`irq_mid`, `irq_lo`) are reported as their present level. A serial input pin is registered once and shown in the status byte. Vectoring, arbitration and the acknowledge cycle belong to the surrounding core.

Top module: `irq_mask_ctl`

## Requirements
- R1: After reset the masks are all 1 (every input masked), `ser_out` is 0, the interrupt enable is 0 and the high pending flag is 0, so `rd_data` reads 8'h07 while the request and serial inputs are low.
- R2: A write whose bit 3 is 1 loads bits 2, 1 and 0 into the masks of `irq_hi`, `irq_mid` and `irq_lo`, effective from the next clock edge; 1 means masked, 0 means enabled.
- R3: A write whose bit 3 is 0 leaves all three masks unchanged, whatever its bits 2..0 hold.
- R4: On a write, bit 7 is copied to `ser_out` at the next edge only when bit 6 of the same byte is 1; otherwise `ser_out` holds its value.
- R5: A rising edge of `irq_hi` (low at one clock edge, high at the next) sets the high pending flag at that edge, and the flag stays set after `irq_hi` falls. A level already high when reset is released is not an edge.
- R6: A write with bit 4 at 1, or an `accept_hi` pulse, clears the high pending flag at the next edge. A new rising edge in that same cycle wins, and the flag stays set.
- R7: `rd_data` is packed as follows:
  - bit 7: `ser_in` as registered at the last clock edge;
  - bit 6: the high pending flag;
  - bits 5 and 4: the present levels of `irq_mid` and `irq_lo`;
  - bit 3: the interrupt enable;
  - bits 2..0: the masks.
  Masks do not hide pending status.
- R8: `ei_stb` sets the interrupt enable at the next edge. `di_stb` or `accept_any` clears it. A clear in the same cycle as a set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle set-mask write strobe |
| wr_data | input | 8 | Set-mask command byte |
| ei_stb | input | 1 | Enable-interrupt strobe |
| di_stb | input | 1 | Disable-interrupt strobe |
| accept_any | input | 1 | Pulse when any interrupt is accepted |
| accept_hi | input | 1 | Pulse when the high-priority interrupt is serviced |
| irq_hi | input | 1 | Edge-sensitive high-priority request |
| irq_mid | input | 1 | Level request, middle priority |
| irq_lo | input | 1 | Level request, lowest priority |
| ser_in | input | 1 | Serial input pin |
| rd_data | output | 8 | Packed status byte |
| ser_out | output | 1 | Serial output latch |

## Verification
The assertions assume that every input is synchronous to `clk` and is stable around the rising edge. They also assume that a strobe which is high for one cycle means exactly one command. They do not assume strobes are exclusive; any strobes may coincide, so the set-versus-clear ordering of R6 and R8 is exercised.

The stimulus changes inputs only shortly after each rising edge and holds them until the next one. The random phase draws strobes with low probability but lets them overlap freely. `irq_hi` is toggled often enough to produce edges that coincide with clears.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int BYTE_W   = 8;
  localparam int MASK_N   = 3;
  localparam int POS_SOD  = 7;
  localparam int POS_SDE  = 6;
  localparam int POS_CLRH = 4;
  localparam int POS_MSE  = 3;
  localparam logic [MASK_N-1:0] MASK_RST = '1;

  function automatic logic [MASK_N-1:0] imc_mask_next(
    input logic [MASK_N-1:0] cur, input logic [BYTE_W-1:0] cmd);
    return cmd[POS_MSE] ? cmd[MASK_N-1:0] : cur;
  endfunction

  function automatic logic imc_sout_next(input logic cur, input logic [BYTE_W-1:0] cmd);
    return cmd[POS_SDE] ? cmd[POS_SOD] : cur;
  endfunction

  function automatic logic [BYTE_W-1:0] imc_pack(
    input logic sin_q, input logic pend_hi, input logic lvl_mid, input logic lvl_lo,
    input logic ien, input logic [MASK_N-1:0] mask);
    return {sin_q, pend_hi, lvl_mid, lvl_lo, ien, mask};
  endfunction
endpackage

// File: rtl/imc_mask_bank.sv
module imc_mask_bank
  import imc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [MASK_N-1:0] mask_q,
  output logic              sout_q
);
  logic mask_load;
  logic sout_load;
  assign mask_load = wr_en & wr_data[POS_MSE];
  assign sout_load = wr_en & wr_data[POS_SDE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      sout_q <= 1'b0;
    end else if (wr_en) begin
      mask_q <= imc_mask_next(mask_q, wr_data);
      sout_q <= imc_sout_next(sout_q, wr_data);
    end
  end

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_load |=> mask_q == $past(wr_data[MASK_N-1:0]));
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_load |=> $stable(mask_q));
  p_sout_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sout_load |=> sout_q == $past(wr_data[POS_SOD]));
  p_sout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sout_load |=> $stable(sout_q));
endmodule

// File: rtl/imc_edge_pend.sv
module imc_edge_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic rise,
  output logic pend
);
  logic lvl_prev;
  assign rise = lvl & ~lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= 1'b1;
      pend     <= 1'b0;
    end else begin
      lvl_prev <= lvl;
      if (rise)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> pend);
  p_hold_no_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !pend);
endmodule

// File: rtl/imc_ien.sv
module imc_ien (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  output logic ien
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien <= 1'b0;
    else if (clr_stb) ien <= 1'b0;
    else if (set_stb) ien <= 1'b1;
  end

  p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> !ien);
  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> ien);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(ien));
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
  import imc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              accept_any,
  input  logic              accept_hi,
  input  logic              irq_hi,
  input  logic              irq_mid,
  input  logic              irq_lo,
  input  logic              ser_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ser_out
);
  logic [MASK_N-1:0] mask_q;
  logic              pend_hi;
  logic              hi_rise;
  logic              hi_clr;
  logic              ien_q;
  logic              ien_clr;
  logic              sin_q;

  assign hi_clr  = (wr_en & wr_data[POS_CLRH]) | accept_hi;
  assign ien_clr = di_stb | accept_any;

  imc_mask_bank u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mask_q(mask_q), .sout_q(ser_out));

  imc_edge_pend u_pend (
    .clk(clk), .rst_n(rst_n), .lvl(irq_hi), .clr(hi_clr),
    .rise(hi_rise), .pend(pend_hi));

  imc_ien u_ien (
    .clk(clk), .rst_n(rst_n), .set_stb(ei_stb), .clr_stb(ien_clr), .ien(ien_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sin_q <= 1'b0;
    else        sin_q <= ser_in;
  end

  assign rd_data = imc_pack(sin_q, pend_hi, irq_mid, irq_lo, ien_q, mask_q);

  p_accept_drops_ien_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_any |=> !rd_data[3]);
  p_accept_hi_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_hi && !hi_rise) |=> !rd_data[6]);
  p_sin_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_data[7] == $past(ser_in));
endmodule

// File: tb/irq_mask_ctl_test.sv
`timescale 1ns/1ps
module irq_mask_ctl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, wr_en, ei_stb, di_stb, accept_any, accept_hi;
  logic       irq_hi, irq_mid, irq_lo, ser_in, ser_out;
  logic [7:0] wr_data, rd_data;

  irq_mask_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ei_stb(ei_stb), .di_stb(di_stb), .accept_any(accept_any), .accept_hi(accept_hi),
    .irq_hi(irq_hi), .irq_mid(irq_mid), .irq_lo(irq_lo), .ser_in(ser_in),
    .rd_data(rd_data), .ser_out(ser_out));

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic [2:0] m_mask;
  logic m_sout, m_ie, m_pend, m_prev, m_sin;

  function automatic logic [7:0] expect_byte();
    logic [7:0] b;
    b[7] = m_sin; b[6] = m_pend; b[5] = irq_mid; b[4] = irq_lo;
    b[3] = m_ie;  b[2:0] = m_mask;
    return b;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic edge_seen;
    @(posedge clk);
    edge_seen = irq_hi & ~m_prev;
    if (wr_en && wr_data[3]) m_mask = wr_data[2:0];
    if (wr_en && wr_data[6]) m_sout = wr_data[7];
    if (edge_seen) m_pend = 1'b1;
    else if ((wr_en && wr_data[4]) || accept_hi) m_pend = 1'b0;
    m_prev = irq_hi;
    if (di_stb || accept_any) m_ie = 1'b0;
    else if (ei_stb) m_ie = 1'b1;
    m_sin = ser_in;
    #1;
  endtask

  task automatic step(input string tag);
    tick();
    chk(tag, rd_data, expect_byte());
    chk({tag, " ser_out"}, {7'd0, ser_out}, {7'd0, m_sout});
    wr_en = 0; ei_stb = 0; di_stb = 0; accept_any = 0; accept_hi = 0;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; wr_en = 0; wr_data = 0; ei_stb = 0; di_stb = 0;
    accept_any = 0; accept_hi = 0;
    irq_hi = 1; irq_mid = 0; irq_lo = 0; ser_in = 0;
    m_mask = 3'b111; m_sout = 0; m_ie = 0; m_pend = 0; m_prev = 1; m_sin = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 reset status", rd_data, 8'h07);
    chk("R1 reset ser_out", {7'd0, ser_out}, 8'h00);

    // R5: level high through reset is no edge
    step("R5 held level");
    chk("R5 no pend", {7'd0, rd_data[6]}, 8'h00);
    irq_hi = 0; step("R5 fall");
    irq_hi = 1; step("R5 rise");
    chk("R5 pend set", {7'd0, rd_data[6]}, 8'h01);
    irq_hi = 0; step("R5 sticky");

    // R6 clear by write (masks untouched, R3)
    wr(8'h10); step("R6 write clear");
    chk("R3 masks kept", {5'd0, rd_data[2:0]}, 8'h07);
    wr(8'h10); irq_hi = 1; step("R6 edge beats clear");
    chk("R6 pend stays", {7'd0, rd_data[6]}, 8'h01);
    accept_hi = 1; step("R6 accept clear");
    chk("R6 pend cleared", {7'd0, rd_data[6]}, 8'h00);

    // R2 / R3
    wr(8'h0A); step("R2 load masks");
    chk("R2 mask 010", {5'd0, rd_data[2:0]}, 8'h02);
    wr(8'h05); step("R3 mse off");
    chk("R3 mask kept", {5'd0, rd_data[2:0]}, 8'h02);

    // R4
    wr(8'h80); step("R4 sde off");
    chk("R4 ser_out 0", {7'd0, ser_out}, 8'h00);
    wr(8'hC0); step("R4 set");
    chk("R4 ser_out 1", {7'd0, ser_out}, 8'h01);
    wr(8'h40); step("R4 clear");

    // R8
    ei_stb = 1; step("R8 enable");
    chk("R8 ie 1", {7'd0, rd_data[3]}, 8'h01);
    ei_stb = 1; di_stb = 1; step("R8 clear wins");
    chk("R8 ie 0", {7'd0, rd_data[3]}, 8'h00);
    ei_stb = 1; step("R8 reenable");
    accept_any = 1; step("R8 accept drops");
    chk("R8 ie after accept", {7'd0, rd_data[3]}, 8'h00);

    // R7
    ser_in = 1; step("R7 serial in");
    chk("R7 bit7", {7'd0, rd_data[7]}, 8'h01);
    irq_mid = 1; #1;
    chk("R7 mid level", rd_data, expect_byte());
    irq_lo = 1; #1;
    chk("R7 lo level", rd_data, expect_byte());

    // random phase
    for (int i = 0; i < 3000; i++) begin
      wr_en      = ($urandom % 4) == 0;
      wr_data    = 8'($urandom);
      ei_stb     = ($urandom % 6) == 0;
      di_stb     = ($urandom % 8) == 0;
      accept_any = ($urandom % 10) == 0;
      accept_hi  = ($urandom % 10) == 0;
      irq_hi     = ($urandom % 2) == 0;
      irq_mid    = ($urandom % 2) == 0;
      irq_lo     = ($urandom % 2) == 0;
      ser_in     = ($urandom % 2) == 0;
      #1;
      chk("R7 random comb", rd_data, expect_byte());
      step("R2 R4 R6 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule